// File: doc/BRIEF.md
# Eight-Bit Bidirectional Shift and Storage Register with Shared Bus

This block is a register of eight bits with four operations: keep the value, shift toward the high end, shift toward the low end, and capture a parallel word. A two-bit select picks the operation, and the register acts on the rising clock edge. Position A is bit 0 and position H is bit 7. Parallel data comes in and the stored value goes out over one shared bus. Here that bus is modelled as a separate input vector, a separate output vector and an output-enable. The bus stops driving whenever the capture operation is selected, so that whatever sits on the bus lines can be clocked in. In the other operations, two active-low output controls decide whether the bus drives.

Two serial outputs always show the two end bits. Joining these to the serial inputs of a neighbouring instance builds longer words. An active-low clear empties the register at once, without a clock. Its release is synchronised to the clock, so the register starts working again on a known edge.

Top module: `univ_shift_reg`

## Requirements
- R1: With select 00 (hold), a clock edge leaves all eight bits unchanged, and both serial inputs have no effect.
- R2: With select 01 (shift right), on each edge bit i takes bit i-1 and bit 0 takes `ser_r_in`.
- R3: With select 10 (shift left), on each edge bit i takes bit i+1 and bit 7 takes `ser_l_in`.
- R4: With select 11 (load), `bus_oe` is 0 whatever the output controls are, and the edge copies `bus_in` into the register.
- R5: In selects 00, 01 and 10, `bus_oe` is 1 exactly when both `out_ctl0_n` and `out_ctl1_n` are 0. `bus_out` equals the register while `bus_oe` is 1 and reads all zeros while it is 0.
- R6: While `clr_n` is 0, the register is zero within the same cycle, without a clock edge, whatever the select and clock do. `end_a`, `end_h` and an enabled `bus_out` then read 0.
- R7: After `clr_n` rises, the first two clock edges leave the register at zero. The third edge acts normally.
- R8: Holding, shifting and loading go on unchanged while the bus is released by the output controls.
- R9: `end_a` always equals bit 0 and `end_h` always equals bit 7, whether the bus is enabled or not.
- R10: Two instances form one 16-bit register in both shift directions. For this, the low instance's `end_h` drives the high instance's `ser_r_in`, and the high instance's `end_a` drives the low instance's `ser_l_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every operation acts on the rising edge |
| clr_n | input | 1 | Active-low clear; asserts asynchronously, release is synchronised |
| mode_sel | input | 2 | Operation select: 00 hold, 01 shift right, 10 shift left, 11 load |
| out_ctl0_n | input | 1 | First active-low bus output control |
| out_ctl1_n | input | 1 | Second active-low bus output control |
| ser_r_in | input | 1 | Serial bit that enters bit 0 during a right shift |
| ser_l_in | input | 1 | Serial bit that enters bit 7 during a left shift |
| bus_in | input | 8 | Value present on the shared bus lines |
| bus_out | output | 8 | Register value driven onto the bus; zero while released |
| bus_oe | output | 1 | High while the block drives the bus |
| end_a | output | 1 | Always shows bit 0 |
| end_h | output | 1 | Always shows bit 7 |

## Verification
A table of steps runs two cascaded instances against a 16-bit model. It mixes loads of unlike patterns (A5, 3C, FF) and shifts that push ones and zeros across the join between the two instances. Some steps drive both serial inputs during hold and drive the unused serial input during shifts, which shows those inputs are ignored. Steps with one output control high, or with both high, show that a released bus costs no state. Directed steps then check the cleared state, the two idle edges after clear release, and a clear asserted in mid-cycle that still wins over a load edge.

// File: rtl/usr_pkg.sv
// Shared types for the universal shift register.
// Assumes: the select encoding below is fixed, since neighbours decode it.
package usr_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD = 2'b00,
        MODE_SHR  = 2'b01,
        MODE_SHL  = 2'b10,
        MODE_LOAD = 2'b11
    } mode_e;

endpackage

// File: rtl/usr_clr_sync.sv
// Clear conditioner: drops run_n as soon as clr_n goes low and raises it
// only after STAGES rising edges with clr_n high.
// Assumes: STAGES >= 1; clk runs while clear is released.
module usr_clr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic clr_n,
    output logic run_n
);

    logic [STAGES-1:0] chain_q;

    // Shift ones in after release; empty the chain at once on clear.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= (chain_q << 1) | {{(STAGES-1){1'b0}}, 1'b1};
        end
    end

    assign run_n = chain_q[STAGES-1];

    // R7: the internal release only follows a clear that was already released.
    p_release_after_clr_r7: assert property (@(posedge clk) disable iff (!clr_n)
        $rose(run_n) |-> $past(clr_n));

endmodule

// File: rtl/usr_next_state.sv
// Next-value logic: builds each register bit from itself, its two
// neighbours, a serial input at the ends, or the parallel word.
// Assumes: W >= 2; bit 0 is the A end, bit W-1 the H end.
module usr_next_state #(
    parameter int W = 8
) (
    input  usr_pkg::mode_e  mode,
    input  logic [W-1:0]    q,
    input  logic            ser_r,
    input  logic            ser_l,
    input  logic [W-1:0]    par,
    output logic [W-1:0]    nxt
);
    import usr_pkg::*;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic from_low;
        logic from_high;

        // Source for a right shift: the bit below, or the serial input at bit 0.
        if (i == 0) begin : g_low_end
            assign from_low = ser_r;
        end else begin : g_low_mid
            assign from_low = q[i-1];
        end

        // Source for a left shift: the bit above, or the serial input at the top.
        if (i == W-1) begin : g_high_end
            assign from_high = ser_l;
        end else begin : g_high_mid
            assign from_high = q[i+1];
        end

        // Per-bit select among hold, the two shift sources and the parallel word.
        assign nxt[i] = (mode == MODE_SHR)  ? from_low  :
                        (mode == MODE_SHL)  ? from_high :
                        (mode == MODE_LOAD) ? par[i]    : q[i];
    end

endmodule

// File: rtl/usr_bus_ctrl.sv
// Bus driver: decides when the register drives the shared bus and
// gates the outgoing value to zero while released.
// Assumes: load mode must always release the bus so it can be captured.
module usr_bus_ctrl #(
    parameter int W = 8
) (
    input  usr_pkg::mode_e  mode,
    input  logic            oc0_n,
    input  logic            oc1_n,
    input  logic [W-1:0]    q,
    output logic            oe,
    output logic [W-1:0]    dout
);
    import usr_pkg::*;

    // Enable only outside load, and only with both controls active.
    assign oe   = (mode != MODE_LOAD) && !oc0_n && !oc1_n;
    // Released bus reads zero so no stale value leaks out.
    assign dout = oe ? q : '0;

endmodule

// File: rtl/univ_shift_reg.sv
// Universal shift/storage register: hold, shift either way, parallel load
// over a shared bus, end-bit serial outputs, asynchronous clear.
// Assumes: bus_in is meaningful on load edges only; clear release is
// synchronised over SYNC_STAGES edges before the register acts again.
module univ_shift_reg #(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic [1:0]   mode_sel,
    input  logic         out_ctl0_n,
    input  logic         out_ctl1_n,
    input  logic         ser_r_in,
    input  logic         ser_l_in,
    input  logic [W-1:0] bus_in,
    output logic [W-1:0] bus_out,
    output logic         bus_oe,
    output logic         end_a,
    output logic         end_h
);
    import usr_pkg::*;

    localparam int TOP = W - 1;

    mode_e        mode;
    logic         run_n;
    logic [W-1:0] q_r;
    logic [W-1:0] q_nxt;

    assign mode = mode_e'(mode_sel);

    usr_clr_sync #(.STAGES(SYNC_STAGES)) clr_sync_i (
        .clk   (clk),
        .clr_n (clr_n),
        .run_n (run_n)
    );

    usr_next_state #(.W(W)) next_i (
        .mode  (mode),
        .q     (q_r),
        .ser_r (ser_r_in),
        .ser_l (ser_l_in),
        .par   (bus_in),
        .nxt   (q_nxt)
    );

    usr_bus_ctrl #(.W(W)) bus_i (
        .mode  (mode),
        .oc0_n (out_ctl0_n),
        .oc1_n (out_ctl1_n),
        .q     (q_r),
        .oe    (bus_oe),
        .dout  (bus_out)
    );

    // State register: cleared at once by run_n, otherwise takes the next value.
    always_ff @(posedge clk or negedge run_n) begin
        if (!run_n) begin
            q_r <= '0;
        end else begin
            q_r <= q_nxt;
        end
    end

    assign end_a = q_r[0];
    assign end_h = q_r[TOP];

    // R1: hold keeps every bit.
    p_hold_r1: assert property (@(posedge clk) disable iff (!run_n)
        (mode_sel == 2'b00) |=> $stable(q_r));

    // R2: right shift moves toward the top and takes ser_r_in at bit 0.
    p_shift_right_r2: assert property (@(posedge clk) disable iff (!run_n)
        (mode_sel == 2'b01) |=> (q_r == {$past(q_r[TOP-1:0]), $past(ser_r_in)}));

    // R3: left shift moves toward bit 0 and takes ser_l_in at the top.
    p_shift_left_r3: assert property (@(posedge clk) disable iff (!run_n)
        (mode_sel == 2'b10) |=> (q_r == {$past(ser_l_in), $past(q_r[TOP:1])}));

    // R4: load captures the bus lines.
    p_load_capture_r4: assert property (@(posedge clk) disable iff (!run_n)
        (mode_sel == 2'b11) |=> (q_r == $past(bus_in)));

    // R4: the bus is never driven while load is selected.
    p_load_bus_off_r4: assert property (@(posedge clk) disable iff (!run_n)
        (mode_sel == 2'b11) |-> !bus_oe);

    // R5: either control high releases the bus and zeroes its output.
    p_bus_release_r5: assert property (@(posedge clk) disable iff (!run_n)
        (out_ctl0_n || out_ctl1_n) |-> (!bus_oe && (bus_out == '0)));

    // R6: clear holds everything at zero, including the end outputs.
    p_clear_zero_r6: assert property (@(posedge clk)
        !clr_n |-> ((q_r == '0) && !end_a && !end_h));

endmodule

// File: tb/univ_shift_reg_tb_top.sv
`timescale 1ns/1ps
module univ_shift_reg_tb_top;

    localparam int  W        = 8;
    localparam time HALF     = 2ns;
    localparam int  WD_CYC   = 5000;
    localparam int  NVEC     = 20;

    // Vector: {mode[1:0], ser_r, ser_l, ctl0_n, ctl1_n, data[7:0]}
    localparam logic [13:0] VEC [NVEC] = '{
        {2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5},
        {2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
        {2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00},
        {2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00},
        {2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00},
        {2'b01, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00},
        {2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00},
        {2'b10, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00},
        {2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00},
        {2'b11, 1'b0, 1'b0, 1'b1, 1'b1, 8'h3C},
        {2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00},
        {2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00},
        {2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
        {2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00},
        {2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
        {2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00},
        {2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF},
        {2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
        {2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00},
        {2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00}
    };

    logic         clk = 1'b0;
    logic         clr_n = 1'b1;
    logic [1:0]   mode_sel = 2'b00;
    logic         ctl0_n = 1'b0;
    logic         ctl1_n = 1'b0;
    logic         ser_r = 1'b0;
    logic         ser_l = 1'b0;
    logic [W-1:0] din = '0;

    logic [W-1:0] lo_bus, hi_bus;
    logic         lo_oe, hi_oe;
    logic         lo_end_a, lo_end_h, hi_end_a, hi_end_h;

    logic [15:0]  model = '0;
    int           n_chk = 0;
    int           n_bad = 0;

    always #HALF clk = ~clk;

    univ_shift_reg #(.W(W)) dut_i (
        .clk        (clk),
        .clr_n      (clr_n),
        .mode_sel   (mode_sel),
        .out_ctl0_n (ctl0_n),
        .out_ctl1_n (ctl1_n),
        .ser_r_in   (ser_r),
        .ser_l_in   (hi_end_a),
        .bus_in     (din),
        .bus_out    (lo_bus),
        .bus_oe     (lo_oe),
        .end_a      (lo_end_a),
        .end_h      (lo_end_h)
    );

    univ_shift_reg #(.W(W)) dut_hi_i (
        .clk        (clk),
        .clr_n      (clr_n),
        .mode_sel   (mode_sel),
        .out_ctl0_n (ctl0_n),
        .out_ctl1_n (ctl1_n),
        .ser_r_in   (lo_end_h),
        .ser_l_in   (ser_l),
        .bus_in     (~din),
        .bus_out    (hi_bus),
        .bus_oe     (hi_oe),
        .end_a      (hi_end_a),
        .end_h      (hi_end_h)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Reference step of the 16-bit word for one running clock edge.
    task automatic model_edge(input logic [1:0] m, input logic sr, input logic sl, input logic [7:0] d);
        case (m)
            2'b01:   model = {model[14:0], sr};
            2'b10:   model = {sl, model[15:1]};
            2'b11:   model = {~d, d};
            default: model = model;
        endcase
    endtask

    // Compare the visible outputs of both halves against the model.
    task automatic check_outputs(input string tag_lo, input string tag_hi);
        logic       eoe;
        logic [7:0] elo, ehi;
        eoe = (mode_sel != 2'b11) && !ctl0_n && !ctl1_n;
        elo = eoe ? model[7:0]  : 8'h00;
        ehi = eoe ? model[15:8] : 8'h00;
        check(tag_lo, {5'b0, lo_end_h, lo_end_a, lo_oe, lo_bus},
                      {5'b0, model[7], model[0], eoe, elo});
        check(tag_hi, {5'b0, hi_end_h, hi_end_a, hi_oe, hi_bus},
                      {5'b0, model[15], model[8], eoe, ehi});
    endtask

    function automatic string mode_tag(input logic [1:0] m, input logic released);
        string s;
        case (m)
            2'b00:   s = "R1 hold";
            2'b01:   s = "R2 shift right";
            2'b10:   s = "R3 shift left";
            default: s = "R4 load";
        endcase
        if (released && m != 2'b11) s = {s, " R8 bus released"};
        return {s, " R5 R9"};
    endfunction

    initial begin : watchdog
        #(WD_CYC * 2 * HALF);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        // Clear asserted shortly after time zero (R6 reset state).
        #1ns clr_n = 1'b0;
        repeat (2) @(negedge clk);
        mode_sel = 2'b00;
        #1ns;
        check_outputs("R6 cleared state lo", "R6 cleared state hi");

        // R7: release, then two load edges must be ignored.
        mode_sel = 2'b11;
        din      = 8'hFF;
        clr_n    = 1'b1;
        repeat (2) @(negedge clk);
        mode_sel = 2'b00;
        din      = 8'h00;
        #1ns;
        check_outputs("R7 idle edges lo", "R7 idle edges hi");

        // R7: the third edge acts.
        @(negedge clk);
        mode_sel = 2'b11;
        din      = 8'hFF;
        @(posedge clk);
        model_edge(2'b11, 1'b0, 1'b0, 8'hFF);
        @(negedge clk);
        mode_sel = 2'b00;
        din      = 8'h00;
        #1ns;
        check_outputs("R7 third edge lo", "R7 third edge hi");

        // Table walk: both instances cascaded against the 16-bit model.
        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk);
            mode_sel = VEC[v][13:12];
            ser_r    = VEC[v][11];
            ser_l    = VEC[v][10];
            ctl0_n   = VEC[v][9];
            ctl1_n   = VEC[v][8];
            din      = (VEC[v][13:12] == 2'b11) ? VEC[v][7:0] : 8'h00;
            @(posedge clk);
            model_edge(VEC[v][13:12], VEC[v][11], VEC[v][10], VEC[v][7:0]);
            #1ns;
            check_outputs(mode_tag(VEC[v][13:12], VEC[v][9] | VEC[v][8]),
                          "R10 cascade upper half");
        end

        // R6: clear in mid-cycle, seen before any clock edge.
        @(negedge clk);
        mode_sel = 2'b00;
        ctl0_n   = 1'b0;
        ctl1_n   = 1'b0;
        ser_r    = 1'b0;
        ser_l    = 1'b0;
        #1ns;
        check_outputs("R6 pre-clear value lo", "R6 pre-clear value hi");
        clr_n = 1'b0;
        model = '0;
        #0.5ns;
        check_outputs("R6 async clear lo", "R6 async clear hi");

        // R6: clear beats a load edge.
        @(negedge clk);
        mode_sel = 2'b11;
        din      = 8'h5A;
        @(posedge clk);
        @(negedge clk);
        mode_sel = 2'b00;
        din      = 8'h00;
        #1ns;
        check_outputs("R6 clear over load lo", "R6 clear over load hi");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule